// File: doc/BRIEF.md
# Programmable Volume Envelope Generator

This block produces a 4-bit volume level that walks through a programmed contour at a programmed rate. The contour is chosen by a 4-bit shape code. The code gives one-shot ramps that fall back to silence, repeating rising or falling sawtooth waves, triangles that alternate direction, and single ramps that stop at the top or at the bottom. Its output feeds the amplitude selection of the sound channels.

A 16-bit step period comes in as a live input. Every level in a ramp lasts sixteen times that period in input clocks. A one-cycle write strobe loads a new shape code. The same strobe restarts the contour from its first level and clears the rate prescaler, so a programmer hears the shape from its beginning on every write.

Top module: `env_shaper`

## Requirements
- R1: After reset, and until the first shape write, `level_o` is 0.
- R2: Each level of a ramp lasts exactly 16 × `period_i` clock cycles. A period of 0 behaves exactly like a period of 1.
- R3: On the clock edge that samples `shape_wr_i` high, the contour and the prescaler restart. From the next cycle the level is 15 if shape bit 2 is 0, or 0 if it is 1. A write takes priority over a step that falls due on the same edge.
- R4: With shape bit 3 = 0, the level makes a single ramp: down 15→0 if bit 2 = 0, up 0→15 if bit 2 = 1. It then shows 0 until the next write.
- R5: With bit 3 = 1, bit 1 = 0 and bit 0 = 0, ramps repeat in the same direction (codes 1000 and 1100), wrapping 0→15 or 15→0 between ramps.
- R6: With bit 3 = 1, bit 1 = 1 and bit 0 = 0, successive ramps alternate direction (codes 1010 and 1110). Each end value appears at the end of one ramp and again at the start of the next.
- R7: With bit 3 = 1 and bit 0 = 1, one ramp is made and the level then stays fixed. It stays at the ramp's final value when bit 1 = 0, and at the opposite extreme when bit 1 = 1 (1001→0, 1011→15, 1101→15, 1111→0).
- R8: Shape field positions: bit 3 is continue, bit 2 is attack (first ramp rises), bit 1 is alternate, and bit 0 is hold. Within a ramp the level moves by exactly one per step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Step period; one level lasts 16 × this many clocks |
| shape_i | input | 4 | Shape code, sampled when the write strobe is high |
| shape_wr_i | input | 1 | Shape write strobe; loads the code and restarts |
| level_o | output | 4 | Current envelope volume level |

## Verification
A shape write and a due step can land on the same clock edge. One would advance the level and the other would restart it. The bench times a second write to reach exactly the edge on which the first rising ramp was about to leave 0. It expects the new falling contour to start at 15 with no trace of the step. The behavioural model compares every cycle around that moment, and a checker property states that any write is followed by the attack-selected start level.

// File: rtl/env_pkg.sv
package env_pkg;
    localparam int LVL_W = 4;

    typedef struct packed {
        logic cont;
        logic attack;
        logic alt;
        logic hold;
    } shape_t;

    typedef struct packed {
        logic [LVL_W-1:0] idx;
        logic             up;
        logic             held;
        logic [LVL_W-1:0] held_lvl;
    } env_state_t;

    function automatic logic [15:0] eff_period(input logic [15:0] p);
        return (p == 16'd0) ? 16'd1 : p;
    endfunction
endpackage

// File: rtl/env_prescaler.sv
module env_prescaler #(
    parameter int PERIOD_W  = 16,
    parameter int PRE_SHIFT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                tick_o
);
    localparam int CNT_W = PERIOD_W + PRE_SHIFT;

    logic [CNT_W-1:0]    cnt_q;
    logic [PERIOD_W-1:0] per_eff;
    logic [CNT_W-1:0]    last;
    logic                wrap;

    assign per_eff = (period_i == '0) ? PERIOD_W'(1) : period_i;
    assign last    = {per_eff, {PRE_SHIFT{1'b0}}} - CNT_W'(1);
    assign wrap    = (cnt_q >= last);
    assign tick_o  = wrap && !restart_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/env_sequencer.sv
module env_sequencer
    import env_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart_i,
    input  shape_t     shape_i,
    input  logic       tick_i,
    output shape_t     shape_o,
    output env_state_t st_o
);
    localparam logic [LVL_W-1:0] TOP = '1;

    shape_t     shape_q;
    env_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shape_q       <= '0;
            st_q.idx      <= '0;
            st_q.up       <= 1'b0;
            st_q.held     <= 1'b1;
            st_q.held_lvl <= '0;
        end else if (restart_i) begin
            shape_q   <= shape_i;
            st_q.idx  <= '0;
            st_q.up   <= shape_i.attack;
            st_q.held <= 1'b0;
        end else if (tick_i && !st_q.held) begin
            if (st_q.idx != TOP) begin
                st_q.idx <= st_q.idx + 1'b1;
            end else if (!shape_q.cont) begin
                st_q.held     <= 1'b1;
                st_q.held_lvl <= '0;
            end else if (shape_q.hold) begin
                st_q.held     <= 1'b1;
                st_q.held_lvl <= {LVL_W{st_q.up ^ shape_q.alt}};
            end else begin
                st_q.idx <= '0;
                st_q.up  <= st_q.up ^ shape_q.alt;
            end
        end
    end

    assign shape_o = shape_q;
    assign st_o    = st_q;
endmodule

// File: rtl/env_level_map.sv
module env_level_map
    import env_pkg::*;
(
    input  env_state_t       st_i,
    output logic [LVL_W-1:0] level_o
);
    always_comb begin
        if (st_i.held)
            level_o = st_i.held_lvl;
        else if (st_i.up)
            level_o = st_i.idx;
        else
            level_o = ~st_i.idx;
    end
endmodule

// File: rtl/env_shaper.sv
module env_shaper
    import env_pkg::*;
#(
    parameter int PERIOD_W  = 16,
    parameter int PRE_SHIFT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [LVL_W-1:0]    shape_i,
    input  logic                shape_wr_i,
    output logic [LVL_W-1:0]    level_o
);
    logic       tick;
    shape_t     shape_cur;
    env_state_t st;
    logic [3:0] shape_bits;
    logic       holding;

    env_prescaler #(.PERIOD_W(PERIOD_W), .PRE_SHIFT(PRE_SHIFT)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .restart_i (shape_wr_i),
        .period_i  (period_i),
        .tick_o    (tick)
    );

    env_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .restart_i (shape_wr_i),
        .shape_i   (shape_t'(shape_i)),
        .tick_i    (tick),
        .shape_o   (shape_cur),
        .st_o      (st)
    );

    env_level_map u_map (
        .st_i    (st),
        .level_o (level_o)
    );

    assign shape_bits = shape_cur;
    assign holding    = st.held;
endmodule

// File: rtl/env_shaper_chk.sv
module env_shaper_chk (
    input logic       clk,
    input logic       rst,
    input logic       shape_wr_i,
    input logic [3:0] shape_i,
    input logic [3:0] level_o,
    input logic [3:0] shape_bits,
    input logic       holding
);
    a_r3_restart_level: assert property (@(posedge clk) disable iff (rst)
        shape_wr_i |=> level_o == ($past(shape_i[2]) ? 4'd0 : 4'd15));

    a_r2_no_back_to_back_steps: assert property (@(posedge clk) disable iff (rst)
        (!$past(shape_wr_i) && level_o != $past(level_o)) |-> ($past(level_o) == $past(level_o, 2)));

    a_r7_held_stable: assert property (@(posedge clk) disable iff (rst)
        (holding && !shape_wr_i) |=> $stable(level_o));

    a_r4_oneshot_silent: assert property (@(posedge clk) disable iff (rst)
        (holding && !shape_bits[3]) |-> level_o == 4'd0);

    a_r5_fall_saw_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(shape_wr_i) && shape_bits == 4'b1000 && level_o != $past(level_o))
            |-> level_o == $past(level_o) - 4'd1);

    a_r5_rise_saw_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(shape_wr_i) && shape_bits == 4'b1100 && level_o != $past(level_o))
            |-> level_o == $past(level_o) + 4'd1);
endmodule

bind env_shaper env_shaper_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .shape_wr_i (shape_wr_i),
    .shape_i    (shape_i),
    .level_o    (level_o),
    .shape_bits (shape_bits),
    .holding    (holding)
);

// File: tb/env_shaper_bench.sv
module env_shaper_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] period = 16'd1;
    logic [3:0]  shape = 4'd0;
    logic        shape_wr = 1'b0;
    logic [3:0]  level;

    always #4 clk = ~clk;

    env_shaper u_env_shaper (
        .clk(clk), .rst(rst), .period_i(period),
        .shape_i(shape), .shape_wr_i(shape_wr), .level_o(level)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cmp_en   = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R1";
    longint cyc_no  = 0;

    // behavioural reference state
    int       m_cyc, m_idx, m_ramp, m_hv;
    bit       m_held = 1'b1;
    bit [3:0] m_shape = 4'd0;

    function automatic int model_level();
        bit up;
        up = m_shape[2] ^ (m_shape[1] & m_ramp[0]);
        if (m_held) return m_hv;
        return up ? m_idx : 15 - m_idx;
    endfunction

    always @(posedge clk) begin
        int lim;
        bit up;
        cyc_no++;
        if (rst) begin
            m_cyc = 0; m_held = 1; m_hv = 0; m_shape = 0; m_idx = 0; m_ramp = 0;
        end else if (shape_wr) begin
            m_shape = shape; m_idx = 0; m_ramp = 0; m_held = 0; m_cyc = 0;
        end else begin
            lim = 16 * ((period == 0) ? 1 : int'(period));
            m_cyc++;
            if (m_cyc >= lim) begin
                m_cyc = 0;
                if (!m_held) begin
                    if (m_idx < 15) m_idx++;
                    else if (!m_shape[3]) begin m_held = 1; m_hv = 0; end
                    else if (m_shape[0]) begin
                        up = m_shape[2] ^ (m_shape[1] & m_ramp[0]);
                        m_held = 1;
                        m_hv = (up ^ m_shape[1]) ? 15 : 0;
                    end else begin
                        m_ramp++; m_idx = 0;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: level=%0d expected=%0d at cycle %0d", req, act, exp, cyc_no);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (cmp_en) check(cur_req, int'(level), model_level());
    end

    task automatic write_shape(input logic [3:0] s);
        @(negedge clk);
        shape = s; shape_wr = 1'b1;
        @(negedge clk);
        shape_wr = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        check("R1 reset level", int'(level), 0);
        cmp_en = 1'b1;
        repeat (100) @(negedge clk);
        check("R1 idle before write", int'(level), 0);

        // every shape code, period 1: R4..R8
        for (int s = 0; s < 16; s++) begin
            if (!s[3])     cur_req = "R4";
            else if (s[0]) cur_req = "R7";
            else if (s[1]) cur_req = "R6";
            else           cur_req = "R5";
            write_shape(4'(s));
            check("R3/R8 start level", int'(level), s[2] ? 0 : 15);
            repeat (16 * 16 * 3 + 40) @(negedge clk);
        end
        cur_req = "R6";
        write_shape(4'b1010);
        repeat (16 * 16 - 1) @(negedge clk);
        check("R6 bottom at end of fall", int'(level), 0);
        repeat (16) @(negedge clk);
        check("R6 bottom repeated", int'(level), 0);
        repeat (16) @(negedge clk);
        check("R6 rising after bottom", int'(level), 1);

        // period 0 acts like 1
        cur_req = "R2";
        period = 16'd0;
        write_shape(4'b1000);
        repeat (15) @(negedge clk);
        check("R2 period0 hold 15", int'(level), 15);
        @(negedge clk);
        check("R2 period0 step", int'(level), 14);
        repeat (600) @(negedge clk);

        // period 3: 48 cycles per level
        period = 16'd3;
        write_shape(4'b1110);
        repeat (47) @(negedge clk);
        check("R2 period3 before step", int'(level), 0);
        @(negedge clk);
        check("R2 period3 step", int'(level), 1);
        repeat (48 * 16 * 2 + 50) @(negedge clk);

        // write on the edge where a step is due
        cur_req = "R3";
        period = 16'd1;
        write_shape(4'b1100);
        repeat (15) @(negedge clk);
        shape = 4'b1000; shape_wr = 1'b1;
        @(negedge clk);
        shape_wr = 1'b0;
        check("R3 write beats step", int'(level), 15);
        repeat (16) @(negedge clk);
        check("R3 prescaler restarted", int'(level), 14);
        repeat (100) @(negedge clk);

        cmp_en = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule